// File: doc/BRIEF.md
# Configurable Integer Min/Max Unit

This unit takes two 64-bit operands and a 3-bit operation code and returns one of the two operands unchanged. The returned operand is either the smaller or the larger of the pair. The code sets three things: how wide the compare is (the low 32 bits or all 64), whether the operands are read as signed or unsigned, and whether the unit picks the minimum or the maximum. When the two operands compare equal, the unit returns the second operand, B.

The compare and the operand select are combinational. The result and its valid flag go into a register, so a request accepted on one clock edge shows its answer after that edge. A word-width compare looks only at bits 31:0, but the unit still forwards the full 64-bit operand it picks, with its upper half as it came in.

Top module: `minmax_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_valid` goes to 0 on that edge.
- R2: `res_valid` on each edge after reset equals the `in_valid` sampled on the same edge, so a result appears exactly one cycle after its request.
- R3: When code bit 0 (LSB) is 0, the unit picks the minimum. It returns A only when A < B strictly, and otherwise returns B.
- R4: When code bit 0 is 1, the unit picks the maximum. It returns A only when A > B strictly, and otherwise returns B.
- R5: If the operands compare equal under the selected width and signedness, the result is B in every one of the eight codes.
- R6: Code bit 1 = 1 selects a two's-complement signed compare, and code bit 1 = 0 selects an unsigned compare.
- R7: Code bit 2 (MSB) = 1 selects a word compare that uses only bits 31:0, so differences in bits 63:32 have no effect on which operand is picked. Code bit 2 = 0 compares all 64 bits.
- R8: The result is always one complete 64-bit input operand, including bits 63:32 in word modes.
- R9: While `in_valid` is 0, `res_data` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| op_code | input | 3 | {word, signed, max} |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_data | output | 64 | Selected operand |

## Verification
The only internal state is the result register and its valid flag, so any fault appears at the ports on the edge right after the request. A wrong compare polarity or a wrong sign flip picks the other operand, and the sign-boundary pairs expose this at once. A wrong width mask shows up when the operands differ only in their upper halves. A wrong tie rule shows up when A and B are equal.

// File: rtl/minmax_pkg.sv
// Package minmax_pkg
// Holds the shared widths and the decoded form of the operation code.
// Assumes the code is packed MSB-first as {word, signed, max}.
package minmax_pkg;
    localparam int DATA_W = 64;
    localparam int WORD_W = 32;
    localparam int CODE_W = 3;

    typedef struct packed {
        logic word_cmp;
        logic signed_cmp;
        logic pick_max;
    } mm_mode_t;

    function automatic mm_mode_t decode_code(input logic [CODE_W-1:0] code);
        mm_mode_t m;
        m.word_cmp   = code[2];
        m.signed_cmp = code[1];
        m.pick_max   = code[0];
        return m;
    endfunction
endpackage

// File: rtl/minmax_keygen.sv
// Module minmax_keygen
// Turns an operand into an unsigned compare key. In word mode the upper
// half is zeroed. In signed mode the sign bit at the active width is
// inverted. Assumes WORD_W < DATA_W.
module minmax_keygen #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] operand,
    input  logic              word_cmp,
    input  logic              signed_cmp,
    output logic [DATA_W-1:0] key
);
    localparam int HI_W = DATA_W - WORD_W;

    // build the key: mask to width, then bias the sign bit
    always_comb begin
        if (word_cmp) begin
            key = {{HI_W{1'b0}}, operand[WORD_W-1:0]};
            key[WORD_W-1] = operand[WORD_W-1] ^ signed_cmp;
        end else begin
            key = operand;
            key[DATA_W-1] = operand[DATA_W-1] ^ signed_cmp;
        end
    end
endmodule

// File: rtl/minmax_compare.sv
// Module minmax_compare
// Compares two unsigned keys and picks an operand. For max, A wins only
// when key A > key B; for min, A wins only when key A < key B. Ties pick B.
module minmax_compare #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] key_a,
    input  logic [DATA_W-1:0] key_b,
    input  logic              pick_max,
    output logic              take_a
);
    // strict compare in the chosen direction
    always_comb begin
        if (pick_max) take_a = key_a > key_b;
        else          take_a = key_a < key_b;
    end
endmodule

// File: rtl/minmax_unit.sv
// Module minmax_unit (top)
// Registered min/max select. Assumes a synchronous active-low reset that
// clears only the valid flag. The data register loads on in_valid only.
module minmax_unit
    import minmax_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [2:0]    op_code,
    output logic          res_valid,
    output logic [DW-1:0] res_data
);
    mm_mode_t      mode;
    logic [DW-1:0] key_a, key_b, pick;
    logic          take_a;

    // split the operation code into its three controls
    always_comb mode = decode_code(op_code);

    minmax_keygen #(.DATA_W(DW), .WORD_W(WW)) u_key_a (
        .operand(op_a), .word_cmp(mode.word_cmp),
        .signed_cmp(mode.signed_cmp), .key(key_a));
    minmax_keygen #(.DATA_W(DW), .WORD_W(WW)) u_key_b (
        .operand(op_b), .word_cmp(mode.word_cmp),
        .signed_cmp(mode.signed_cmp), .key(key_b));
    minmax_compare #(.DATA_W(DW)) u_cmp (
        .key_a(key_a), .key_b(key_b), .pick_max(mode.pick_max),
        .take_a(take_a));

    // forward the whole winning operand
    always_comb pick = take_a ? op_a : op_b;

    // valid flag register
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= in_valid;
    end

    // result register, loaded only on a request
    always_ff @(posedge clk) begin
        if (in_valid) res_data <= pick;
    end

    // R1: reset clears valid on the following edge
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !res_valid);
    // R2: valid follows the request one cycle later
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    // R8: the result equals one of the two operands that were sampled
    a_r8_is_operand: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_data == $past(op_a) || res_data == $past(op_b)));
    // R5: when the operands are identical, the result is B
    a_r5_tie_b: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a == op_b) |=> res_data == $past(op_b));
    // R9: the result holds while no request is made
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_data));
endmodule

// File: tb/minmax_unit_bench.sv
module minmax_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [2:0]  op_code = '0;
    logic        res_valid;
    logic [63:0] res_data;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    minmax_unit u_minmax_unit (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_code(op_code),
        .res_valid(res_valid), .res_data(res_data));

    // reference model written from the requirements
    function automatic logic [63:0] ref_pick(input logic [63:0] a, b, input logic [2:0] c);
        logic signed [64:0] ka, kb;
        logic win;
        if (c[2]) begin
            ka = c[1] ? {{33{a[31]}}, a[31:0]} : {33'd0, a[31:0]};
            kb = c[1] ? {{33{b[31]}}, b[31:0]} : {33'd0, b[31:0]};
        end else begin
            ka = c[1] ? {a[63], a} : {1'b0, a};
            kb = c[1] ? {b[63], b} : {1'b0, b};
        end
        win = c[0] ? (ka > kb) : (ka < kb);
        return win ? a : b;
    endfunction

    task automatic check(input string req, input logic [63:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one request, then sample after the edge
    task automatic run(input string req, input logic [63:0] a, b, input logic [2:0] c);
        @(negedge clk);
        op_a = a; op_b = b; op_code = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {63'd0, res_valid}, 64'd1);
        check(req, res_data, ref_pick(a, b, c));
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R1", {63'd0, res_valid}, 64'd0);
        in_valid = 1'b0; rst_n = 1'b1;
    endtask

    task automatic t_basic();
        run("R3", 64'd5, 64'd9, 3'b000);
        run("R3", 64'd9, 64'd5, 3'b000);
        run("R4", 64'd5, 64'd9, 3'b001);
        run("R4", 64'd9, 64'd5, 3'b001);
    endtask

    task automatic t_equal();
        for (int c = 0; c < 8; c++) begin
            run("R5", 64'hAAAA_0000_0000_1234, 64'hAAAA_0000_0000_1234, 3'(c));
            // equal in the low word, different upper halves: word modes give B
            if (c >= 4) begin
                run("R5", 64'h1111_1111_0000_0042, 64'h2222_2222_0000_0042, 3'(c));
                check("R5", res_data, 64'h2222_2222_0000_0042);
            end
        end
    endtask

    task automatic t_sign();
        for (int c = 0; c < 8; c++) begin
            run("R6", 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000, 3'(c));
            run("R6", 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 3'(c));
            run("R6", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'(c));
        end
        run("R6", 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 3'b110);
        check("R6", res_data, 64'h0000_0000_8000_0000);
    endtask

    task automatic t_word();
        run("R7", 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_0000_0002, 3'b100);
        check("R8", res_data, 64'hFFFF_FFFF_0000_0001);
        run("R7", 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_0000_0002, 3'b000);
        check("R7", res_data, 64'h0000_0000_0000_0002);
        run("R7", 64'h0000_0000_0000_0003, 64'h8000_0000_0000_0002, 3'b111);
        check("R8", res_data, 64'h0000_0000_0000_0003);
    endtask

    task automatic t_hold();
        logic [63:0] keep;
        run("R2", 64'd7, 64'd3, 3'b001);
        keep = res_data;
        @(negedge clk); op_a = 64'd100; op_b = 64'd200;
        @(negedge clk);
        check("R9", res_data, keep);
        check("R2", {63'd0, res_valid}, 64'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check("R1", {63'd0, res_valid}, 64'd0);
                rst_n = 1'b1;
                t_basic();
                t_equal();
                t_sign();
                t_word();
                t_hold();
                t_reset();
                run("R2", 64'd1, 64'd2, 3'b010);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule